// File: doc/BRIEF.md
# Line Latch with Polarity Steering

This block sits at the back end of a column driver. A line of gray codes, one per channel, is loaded into a data register by upstream logic. A strobe then moves the whole line into an output latch in a single step. From that point the latched codes feed the digital-to-analog stage, and the data register is free to load the next line.

For each channel the block also produces a reference-bank select. Adjacent channels always take opposite banks, and a polarity input chooses which way round the pairing goes. This supports dot, n-line and column inversion. The polarity value is captured at the same strobe edge as the codes, so it belongs to that line.

The block also produces a single drive-enable for all channels. It models the high-impedance window: while the strobe is high the channels are released, and they drive again once the strobe falls. The strobe is sampled on the block clock, and every output is a register.

Top module: `line_latch_steer`

## Requirements
- R1: During and after reset, before any strobe: every code is 0, drive_en is 0, every channel with an even index (0, 2, ...) has bank bit 0 and every channel with an odd index has bank bit 1.
- R2: On the first clock edge at which strobe is sampled high after being low, the latch captures line_data, and code_out shows it from the following cycle. Channel k occupies bits [k*CODE_W +: CODE_W].
- R3: While strobe stays low, code_out does not change, whatever happens on line_data.
- R4: On the clock edge at which strobe is first sampled high, drive_en is cleared. It stays 0 for as long as strobe is sampled high.
- R5: On the first clock edge at which strobe is sampled low after being high, drive_en is set to 1.
- R6: If pol is 0 at the capturing edge, every even-index channel gets bank bit 0 (upper bank) and every odd-index channel gets bank bit 1 (lower bank).
- R7: If pol is 1 at the capturing edge, the assignment swaps: even-index channels get 1 and odd-index channels get 0.
- R8: Changes on pol at any edge other than the capturing edge leave bank_sel unchanged.
- R9: Neighbouring channels 2j and 2j+1 always hold opposite bank bits.
- R10: Keeping strobe high for several cycles gives one capture only. Changes on line_data after the first high cycle do not reach code_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| line_data | input | CH_COUNT*CODE_W | Data register contents, channel k at bits [k*CODE_W +: CODE_W] |
| strobe | input | 1 | Line transfer strobe |
| pol | input | 1 | Polarity: 0 puts even-index channels on the upper bank, 1 puts them on the lower bank |
| code_out | output | CH_COUNT*CODE_W | Latched gray codes |
| bank_sel | output | CH_COUNT | Per-channel bank select: 0 = upper, 1 = lower |
| drive_en | output | 1 | Shared output enable; 0 models the high-impedance window |

## Verification
The hardest case to reach is a strobe held high for several cycles while both line_data and pol change underneath it. A design that captures on the level of the strobe, rather than on its edge, would pick up the late values. The stimulus therefore changes the data and inverts the polarity in the cycle right after the capture, keeps the strobe high for between one and four more cycles, and then checks that the first line and its banks survive. The same changes are repeated during the low phase to confirm that both the codes and the banks hold.

// File: rtl/lls_pkg.sv
package lls_pkg;
  typedef enum logic {
    BANK_UPPER = 1'b0,
    BANK_LOWER = 1'b1
  } bank_e;
endpackage

// File: rtl/lls_strobe_edge.sv
module lls_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise,
  output logic fall,
  output logic drive_en
);
  logic strobe_q;

  assign rise = strobe & ~strobe_q;
  assign fall = ~strobe & strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (rise)      drive_en <= 1'b0;
      else if (fall) drive_en <= 1'b1;
    end
  end

  // R4: output released once the strobe is seen high
  a_r4_dark_on_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !drive_en);
  // R5: output driven again after the strobe falls
  a_r5_drive_on_fall: assert property (@(posedge clk) disable iff (rst)
    fall |=> drive_en);
endmodule

// File: rtl/lls_code_latch.sv
module lls_code_latch #(
  parameter int WIDTH = 2304
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (capture) q <= d;
  end

  // R2: captured line equals data present at the capturing edge
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    capture |=> (q == $past(d)));
  // R3: latch holds between captures
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(q));
endmodule

// File: rtl/lls_bank_steer.sv
module lls_bank_steer
  import lls_pkg::*;
#(
  parameter int CH_COUNT = 384
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic                pol,
  output logic [CH_COUNT-1:0] bank
);
  for (genvar i = 0; i < CH_COUNT; i++) begin : g_ch
    localparam logic ODD_IDX = 1'(i % 2);
    always_ff @(posedge clk) begin
      if (rst)          bank[i] <= (ODD_IDX ? BANK_LOWER : BANK_UPPER);
      else if (capture) bank[i] <= pol ^ ODD_IDX;
    end
  end

  // R8: banks frozen except at a capture
  a_r8_pol_frozen: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(bank));
  // R6: low polarity puts channel 0 on the upper bank
  a_r6_low_pol: assert property (@(posedge clk) disable iff (rst)
    (capture && !pol) |=> (bank[0] == BANK_UPPER));
  // R7: high polarity puts channel 0 on the lower bank
  a_r7_high_pol: assert property (@(posedge clk) disable iff (rst)
    (capture && pol) |=> (bank[0] == BANK_LOWER));
endmodule

// File: rtl/line_latch_steer.sv
module line_latch_steer #(
  parameter int CH_COUNT = 384,
  parameter int CODE_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CH_COUNT*CODE_W-1:0] line_data,
  input  logic                       strobe,
  input  logic                       pol,
  output logic [CH_COUNT*CODE_W-1:0] code_out,
  output logic [CH_COUNT-1:0]        bank_sel,
  output logic                       drive_en
);
  localparam int LINE_W = CH_COUNT * CODE_W;

  logic st_rise;
  logic st_fall;

  lls_strobe_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rise     (st_rise),
    .fall     (st_fall),
    .drive_en (drive_en)
  );

  lls_code_latch #(.WIDTH(LINE_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (st_rise),
    .d       (line_data),
    .q       (code_out)
  );

  lls_bank_steer #(.CH_COUNT(CH_COUNT)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .capture (st_rise),
    .pol     (pol),
    .bank    (bank_sel)
  );

  // R9: the first pair of channels never share a bank
  if (CH_COUNT > 1) begin : g_pair_chk
    a_r9_pair_opposite: assert property (@(posedge clk) disable iff (rst)
      st_rise |=> (bank_sel[0] != bank_sel[1]));
  end
endmodule

// File: tb/line_latch_steer_bench.sv
module line_latch_steer_bench;
  localparam int CH = 384;
  localparam int W  = 6;
  localparam int LW = CH * W;

  typedef struct {
    logic [LW-1:0] codes;
    logic          p;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] line_data = '0;
  logic          strobe = 1'b0;
  logic          pol = 1'b0;
  logic [LW-1:0] code_out;
  logic [CH-1:0] bank_sel;
  logic          drive_en;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  line_latch_steer u_line_latch_steer (
    .clk(clk), .rst(rst), .line_data(line_data), .strobe(strobe),
    .pol(pol), .code_out(code_out), .bank_sel(bank_sel), .drive_en(drive_en)
  );

  function automatic logic [LW-1:0] pat(int s);
    logic [LW-1:0] v;
    for (int ch = 0; ch < CH; ch++) v[ch*W +: W] = 6'((ch * s + s * 7 + (ch >> 3)) & 63);
    return v;
  endfunction

  function automatic logic [CH-1:0] bank_exp(logic p);
    logic [CH-1:0] b;
    for (int ch = 0; ch < CH; ch++) b[ch] = p ^ 1'(ch % 2);
    return b;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: a rising drive_en completes one line; compare with scoreboard
  logic prev_en = 1'b0;
  always @(negedge clk) begin
    if (!rst && drive_en && !prev_en) begin
      if (sb.size() == 0) begin
        chk(0, "R2 unexpected line", 64'(drive_en), 64'd0);
      end else begin
        exp_t e;
        logic pair_ok;
        e = sb.pop_front();
        chk(code_out == e.codes, "R2 line codes", code_out[63:0], e.codes[63:0]);
        chk(bank_sel == bank_exp(e.p), e.p ? "R7 banks" : "R6 banks",
            bank_sel[63:0], bank_exp(e.p)[63:0]);
        pair_ok = 1'b1;
        for (int j = 0; j < CH / 2; j++)
          if (bank_sel[2*j] == bank_sel[2*j+1]) pair_ok = 1'b0;
        chk(pair_ok, "R9 pairs opposite", bank_sel[63:0], ~bank_sel[63:0]);
      end
    end
    prev_en <= drive_en;
  end

  task automatic run_line(int seed, logic p, int hi_cyc, int lo_cyc);
    @(negedge clk);
    line_data = pat(seed);
    pol = p;
    strobe = 1'b1;
    sb.push_back('{pat(seed), p});
    @(negedge clk);
    chk(drive_en == 1'b0, "R4 released", 64'(drive_en), 64'd0);
    chk(code_out == pat(seed), "R2 immediate", code_out[63:0], pat(seed)[63:0]);
    line_data = pat(seed + 100);
    pol = ~p;
    for (int k = 0; k < hi_cyc; k++) begin
      @(negedge clk);
      chk(drive_en == 1'b0, "R4 stays low", 64'(drive_en), 64'd0);
    end
    chk(code_out == pat(seed), "R10 single capture", code_out[63:0], pat(seed)[63:0]);
    chk(bank_sel == bank_exp(p), "R8 pol late", bank_sel[63:0], bank_exp(p)[63:0]);
    strobe = 1'b0;
    @(negedge clk);
    chk(drive_en == 1'b1, "R5 driven", 64'(drive_en), 64'd1);
    for (int k = 0; k < lo_cyc; k++) begin
      line_data = pat(seed + 200 + k);
      pol = ~pol;
      @(negedge clk);
    end
    chk(code_out == pat(seed), "R3 hold while low", code_out[63:0], pat(seed)[63:0]);
    chk(bank_sel == bank_exp(p), "R8 pol while low", bank_sel[63:0], bank_exp(p)[63:0]);
    chk(drive_en == 1'b1, "R5 stays driven", 64'(drive_en), 64'd1);
  endtask

  initial begin
    line_data = pat(5);
    pol = 1'b1;
    repeat (3) @(negedge clk);
    chk(code_out == '0, "R1 codes", code_out[63:0], 64'd0);
    chk(drive_en == 1'b0, "R1 drive", 64'(drive_en), 64'd0);
    chk(bank_sel == bank_exp(1'b0), "R1 banks", bank_sel[63:0], bank_exp(1'b0)[63:0]);
    rst = 1'b0;
    pol = 1'b0;
    repeat (2) @(negedge clk);
    chk(drive_en == 1'b0, "R1 drive before strobe", 64'(drive_en), 64'd0);
    chk(code_out == '0, "R1 codes before strobe", code_out[63:0], 64'd0);
    run_line(3, 1'b0, 1, 5);
    run_line(11, 1'b1, 4, 3);
    run_line(17, 1'b1, 2, 6);
    run_line(29, 1'b0, 3, 2);
    run_line(63, 1'b1, 1, 4);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R2 all lines seen", 64'(sb.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule